// File: doc/BRIEF.md
# Periodic Event and Tone Generator

This block turns a 32.768 kHz clock into slow periodic events and an audible tone. A binary prescaler counts clock cycles. One of eight taps on it sets the overflow rate, from 1 Hz up to 128 Hz. Each overflow of the selected tap is a tick.

A tick can do two things. It can latch an event flag directly, when the time base is on. It can also advance a watchdog counter, when the watchdog is on; after a set number of ticks the watchdog counter latches the same flag. The flag drives an active-low interrupt output, meant for an open-drain pad outside the block.

A small divider on the same clock drives a complementary buzzer pair at either 2 kHz or 4 kHz. A power-down command halts the prescaler and the tone. The host controls everything through single-cycle command strobes. Commands are plain control, so there is no handshake: every strobe is accepted in the cycle it is presented.

Top module: `tbw_timer`

## Requirements
- R1: After reset, irq_n is high and both buzzer outputs are low. The time base, watchdog, tone and interrupt are all disabled. The rate code is 0, the tone is set to 2 kHz, and the block is powered up.
- R2: Rate code k (cmd_arg of the rate command) makes the selected tap overflow every 32768 >> k clock cycles, which is 2^k Hz. After a clear command taking effect at edge P, the first overflow flag is set at edge P + (32768 >> k).
- R3: While the time base is enabled, every overflow of the selected tap sets the event flag.
- R4: While the watchdog is enabled, the flag is set on every 4th tick counted since the last clear. With both the time base and the watchdog disabled, the prescaler holds and the flag never sets.
- R5: Once set, the flag stays set until a clear command arrives. The clear zeroes the prescaler, the watchdog count and the flag, all in the same edge.
- R6: irq_n is low exactly when the flag is set and the interrupt is enabled. Disabling the interrupt drives irq_n high but keeps the flag, so enabling the interrupt again drives irq_n low.
- R7: With the tone on and the block powered up, buzz_p is a square wave with a period of 16 clocks (2 kHz) or 8 clocks (4 kHz), and buzz_n is always its complement.
- R8: With the tone off, buzz_p and buzz_n are both low.
- R9: Power-down freezes the prescaler and the watchdog count at their current values and forces both buzzer outputs low. Power-up resumes counting from the frozen value.
- R10: Each command takes effect at the clock edge that samples cmd_stb high. The cmd_op codes are:

  | Code | Command |
  |------|---------|
  | 0 | no operation |
  | 1 | time base on |
  | 2 | time base off |
  | 3 | watchdog on |
  | 4 | watchdog off |
  | 5 | clear |
  | 6 | tone on |
  | 7 | tone off |
  | 8 | 2 kHz tone |
  | 9 | 4 kHz tone |
  | 10 | interrupt on |
  | 11 | interrupt off |
  | 12 | load rate code from cmd_arg |
  | 13 | power down |
  | 14 | power up |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_stb | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 4 | Command code, see R10 |
| cmd_arg | input | 3 | Rate code for the rate command |
| irq_n | output | 1 | Active-low event output |
| buzz_p | output | 1 | Tone output |
| buzz_n | output | 1 | Complementary tone output |

## Verification
A wrong prescaler tap or a miscounted watchdog shows up only as an early or late fall of irq_n. The bench therefore counts the exact cycle of the first fall after each clear, at five rates and for the watchdog. A flag that leaks or a clear that misses the watchdog count would be visible within one tick period, at most 32768 cycles. A tone divider fault shows within 16 cycles as a wrong buzz_p period or a pair that is not complementary. A power-down that loses the prescaler value shows as a shifted overflow cycle after power-up.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_TB_ON   = 4'd1,
    OP_TB_OFF  = 4'd2,
    OP_WD_ON   = 4'd3,
    OP_WD_OFF  = 4'd4,
    OP_CLEAR   = 4'd5,
    OP_TONE_ON = 4'd6,
    OP_TONE_OFF= 4'd7,
    OP_TONE_LO = 4'd8,
    OP_TONE_HI = 4'd9,
    OP_IRQ_ON  = 4'd10,
    OP_IRQ_OFF = 4'd11,
    OP_RATE    = 4'd12,
    OP_SLEEP   = 4'd13,
    OP_WAKE    = 4'd14
  } tbw_op_e;
endpackage

// File: rtl/tbw_ctrl.sv
module tbw_ctrl
  import tbw_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_stb,
  input  logic [3:0]       cmd_op,
  input  logic [SEL_W-1:0] cmd_arg,
  output logic             tb_en,
  output logic             wd_en,
  output logic             tone_en,
  output logic             tone_fast,
  output logic             irq_en,
  output logic             sleep,
  output logic [SEL_W-1:0] rate_sel,
  output logic             clr
);
  tbw_op_e op;
  assign op  = tbw_op_e'(cmd_op);
  // R5: clear acts in the same edge that samples the strobe
  assign clr = cmd_stb && (op == OP_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_en     <= 1'b0;
      wd_en     <= 1'b0;
      tone_en   <= 1'b0;
      tone_fast <= 1'b0;
      irq_en    <= 1'b0;
      sleep     <= 1'b0;
      rate_sel  <= '0;
    end else if (cmd_stb) begin
      case (op)
        OP_TB_ON:    tb_en     <= 1'b1;
        OP_TB_OFF:   tb_en     <= 1'b0;
        OP_WD_ON:    wd_en     <= 1'b1;
        OP_WD_OFF:   wd_en     <= 1'b0;
        OP_TONE_ON:  tone_en   <= 1'b1;
        OP_TONE_OFF: tone_en   <= 1'b0;
        OP_TONE_LO:  tone_fast <= 1'b0;
        OP_TONE_HI:  tone_fast <= 1'b1;
        OP_IRQ_ON:   irq_en    <= 1'b1;
        OP_IRQ_OFF:  irq_en    <= 1'b0;
        OP_RATE:     rate_sel  <= cmd_arg;
        OP_SLEEP:    sleep     <= 1'b1;
        OP_WAKE:     sleep     <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tbw_prescaler.sv
module tbw_prescaler #(
  parameter int PRESC_W   = 15,
  parameter int NUM_RATES = 8,
  parameter int SEL_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRESC_W-1:0]   cnt_q;
  logic [NUM_RATES-1:0] tap_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + 1'b1;
  end

  // rate code g: low PRESC_W-g bits all ones, period 2^(PRESC_W-g)
  for (genvar g = 0; g < NUM_RATES; g++) begin : g_tap
    localparam int TOP = PRESC_W - 1 - g;
    assign tap_hit[g] = &cnt_q[TOP:0];
  end

  assign tick = run && tap_hit[sel];

  assert_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt_q));
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/tbw_event.sv
module tbw_event #(
  parameter int WDT_TICKS = 4,
  localparam int WDT_W    = (WDT_TICKS > 1) ? $clog2(WDT_TICKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tb_en,
  input  logic wd_en,
  input  logic clr,
  output logic flag
);
  logic [WDT_W-1:0] wd_cnt;
  logic             wd_wrap;

  assign wd_wrap = wd_en && tick && (wd_cnt == WDT_W'(WDT_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_cnt <= '0;
      flag   <= 1'b0;
    end else if (clr) begin
      wd_cnt <= '0;
      flag   <= 1'b0;
    end else begin
      if (wd_en && tick) wd_cnt <= wd_wrap ? '0 : wd_cnt + 1'b1;
      if ((tb_en && tick) || wd_wrap) flag <= 1'b1;
    end
  end

  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  assert_flag_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick));
endmodule

// File: rtl/tbw_tone.sv
module tbw_tone #(
  parameter int DIV_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic fast,
  output logic buzz_p,
  output logic buzz_n
);
  logic [DIV_W-1:0] div_q;
  logic             phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (active)  div_q <= div_q + 1'b1;
    else              div_q <= '0;
  end

  assign phase  = fast ? div_q[DIV_W-2] : div_q[DIV_W-1];
  assign buzz_p = active && phase;
  assign buzz_n = active && !phase;
endmodule

// File: rtl/tbw_timer.sv
module tbw_timer #(
  parameter int PRESC_W    = 15,
  parameter int NUM_RATES  = 8,
  parameter int WDT_TICKS  = 4,
  parameter int TONE_DIV_W = 4,
  localparam int SEL_W     = $clog2(NUM_RATES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_stb,
  input  logic [3:0]       cmd_op,
  input  logic [SEL_W-1:0] cmd_arg,
  output logic             irq_n,
  output logic             buzz_p,
  output logic             buzz_n
);
  logic tb_en, wd_en, tone_en, tone_fast, irq_en, sleep, clr, tick, flag;
  logic [SEL_W-1:0] rate_sel;
  logic run, tone_act;

  tbw_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .tb_en(tb_en), .wd_en(wd_en), .tone_en(tone_en),
    .tone_fast(tone_fast), .irq_en(irq_en), .sleep(sleep),
    .rate_sel(rate_sel), .clr(clr)
  );

  assign run      = (tb_en || wd_en) && !sleep;
  assign tone_act = tone_en && !sleep;

  tbw_prescaler #(.PRESC_W(PRESC_W), .NUM_RATES(NUM_RATES), .SEL_W(SEL_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(clr), .sel(rate_sel), .tick(tick)
  );

  tbw_event #(.WDT_TICKS(WDT_TICKS)) u_event (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tb_en(tb_en), .wd_en(wd_en),
    .clr(clr), .flag(flag)
  );

  tbw_tone #(.DIV_W(TONE_DIV_W)) u_tone (
    .clk(clk), .rst_n(rst_n), .active(tone_act), .fast(tone_fast),
    .buzz_p(buzz_p), .buzz_n(buzz_n)
  );

  assign irq_n = !(flag && irq_en);

  assert_pair_compl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tone_act |-> (buzz_p != buzz_n));
  assert_pair_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_en |-> (!buzz_p && !buzz_n));
  assert_irq_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> irq_n);
  assert_no_tick_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tb_en && !wd_en) |-> !tick);
endmodule

// File: tb/tb_tbw_timer.sv
module tb_tbw_timer;
  import tbw_pkg::*;
  localparam int CLK_PERIOD = 10;
  // rate code, expected cycles from clear to irq_n low
  localparam int VEC [5][2] = '{'{7, 256}, '{6, 512}, '{5, 1024}, '{4, 2048}, '{3, 4096}};

  logic clk = 1'b0, rst_n = 1'b0, cmd_stb = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [2:0] cmd_arg = '0;
  logic irq_n, buzz_p, buzz_n;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbw_timer dut (.clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
                 .cmd_arg(cmd_arg), .irq_n(irq_n), .buzz_p(buzz_p), .buzz_n(buzz_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmd(input tbw_op_e op, input int arg = 0);
    @(negedge clk);
    cmd_stb = 1'b1; cmd_op = op; cmd_arg = 3'(arg);
    @(negedge clk);
    cmd_stb = 1'b0; cmd_op = OP_NOP;
  endtask

  task automatic wait_irq(input int lim, output int n);
    n = 0;
    while (irq_n && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic tone_period(output int per);
    bit prev;
    int k;
    per = 0;
    prev = buzz_p; k = 0;
    while (!(prev == 1'b0 && buzz_p == 1'b1) && k < 64) begin
      prev = buzz_p; @(negedge clk); k++;
    end
    prev = buzz_p;
    @(negedge clk); per = 1;
    while (!(prev == 1'b0 && buzz_p == 1'b1) && per < 64) begin
      prev = buzz_p; @(negedge clk); per++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n, per, bad;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
    check(buzz_p == 1'b0, "R1 buzz_p", buzz_p, 0);
    check(buzz_n == 1'b0, "R1 buzz_n", buzz_n, 0);
    rst_n = 1'b1;
    @(negedge clk);

    cmd(OP_IRQ_ON);
    cmd(OP_TB_ON);
    // R2 R3: table of rates, overflow cycle counted from clear
    for (int i = 0; i < 5; i++) begin
      cmd(OP_RATE, VEC[i][0]);
      cmd(OP_CLEAR);
      wait_irq(40000, n);
      check(n == VEC[i][1], "R2 rate period", n, VEC[i][1]);
    end
    // R2: slowest rate, 1 Hz
    cmd(OP_RATE, 0);
    cmd(OP_CLEAR);
    wait_irq(40000, n);
    check(n == 32768, "R2 rate 0", n, 32768);

    // R6: masking keeps the flag
    cmd(OP_IRQ_OFF);
    check(irq_n == 1'b1, "R6 masked", irq_n, 1);
    cmd(OP_IRQ_ON);
    check(irq_n == 1'b0, "R6 unmasked flag kept", irq_n, 0);

    // R4: watchdog alone, 4 ticks
    cmd(OP_RATE, 7);
    cmd(OP_TB_OFF);
    cmd(OP_WD_ON);
    cmd(OP_CLEAR);
    wait_irq(5000, n);
    check(n == 1024, "R4 watchdog period", n, 1024);
    // R5: flag held
    repeat (300) @(negedge clk);
    check(irq_n == 1'b0, "R5 flag held", irq_n, 0);
    cmd(OP_CLEAR);
    check(irq_n == 1'b1, "R5 clear drops flag", irq_n, 1);
    // R5: clear resets watchdog count
    repeat (598) @(negedge clk);
    cmd(OP_CLEAR);
    wait_irq(5000, n);
    check(n == 1024, "R5 watchdog count cleared", n, 1024);

    // R4: both disabled, nothing happens
    cmd(OP_WD_OFF);
    cmd(OP_CLEAR);
    wait_irq(2000, n);
    check(irq_n == 1'b1, "R4 idle no flag", irq_n, 1);

    // R9: power down freezes the prescaler
    cmd(OP_TB_ON);
    cmd(OP_CLEAR);
    repeat (99) @(negedge clk);
    cmd(OP_SLEEP);
    repeat (1000) @(negedge clk);
    check(irq_n == 1'b1, "R9 frozen", irq_n, 1);
    cmd(OP_WAKE);
    wait_irq(2000, n);
    check(n == 155, "R9 resume", n, 155);

    // R7: tone
    cmd(OP_TONE_ON);
    tone_period(per);
    check(per == 16, "R7 2kHz period", per, 16);
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (buzz_p == buzz_n) bad++;
    end
    check(bad == 0, "R7 complement", bad, 0);
    cmd(OP_TONE_HI);
    tone_period(per);
    check(per == 8, "R7 4kHz period", per, 8);
    // R8: tone off
    cmd(OP_TONE_OFF);
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (buzz_p || buzz_n) bad++;
    end
    check(bad == 0, "R8 quiet pair", bad, 0);
    // R9: sleep silences the tone
    cmd(OP_TONE_ON);
    cmd(OP_SLEEP);
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (buzz_p || buzz_n) bad++;
    end
    check(bad == 0, "R9 sleep quiet", bad, 0);
    // R10: no-op changes nothing while asleep
    cmd(OP_NOP);
    check(!buzz_p && !buzz_n, "R10 nop", buzz_p, 0);
    cmd(OP_WAKE);
    tone_period(per);
    check(per == 8, "R9 wake tone", per, 8);

    finish_run();
  end
endmodule